// File: doc/BRIEF.md
# Pointer-Register Address Generator

This block turns a memory-access operation into a concrete address for data memory or program memory. It picks one of three 16-bit pointer pairs, where each pair is its high byte placed above its low byte. It then applies the addressing mode: plain use, pre-decrement, post-increment, or an unsigned displacement. A direct mode takes a 16-bit operand word as the address instead of a pointer. Program-memory reads always go through the third pointer pair. An extended form of that read places a 6-bit page value above the pointer to make a 22-bit address.

For the modes that modify the pointer, the block also supplies the updated pointer bytes, the updated page value and their write strobes. These all appear in the same cycle as the memory request. The decoder presents one operation per cycle with `op_valid`. Every output is registered, so the request and its write-back appear on the clock edge after the operation is accepted. The memories and the register file are outside the block.

Top module: `ptr_agu`

## Requirements
- R1: Pointer codes on `ptr_sel` are 0 for the first pair (x_hi:x_lo), 1 for the second (y_hi:y_lo), and 2 or 3 for the third (z_hi:z_lo). In plain mode (code 0), `mem_addr` is the selected pointer with bits 21:16 zero, and `wb_en` is 0.
- R2: In pre-decrement mode (code 1), both `mem_addr[15:0]` and the write-back bytes equal the pointer minus one, and `wb_en` is 1.
- R3: In post-increment mode (code 2), `mem_addr[15:0]` is the unchanged pointer, the write-back bytes hold the pointer plus one, and `wb_en` is 1.
- R4: In displacement mode (code 3), the address is the pointer plus the zero-extended 6-bit `disp`, and there is no write-back. When the first pair is selected, `disp` is ignored and the address is the pointer itself.
- R5: In direct mode (code 4), `mem_addr` is `operand` zero-extended, and there is no write-back.
- R6: Program read modes 5 (plain) and 6 (post-increment) always use the third pair. They give the 16-bit address with bits 21:16 zero. Mode 6 writes back the pointer plus one modulo 2^16 and leaves the page alone (`page_we` is 0).
- R7: Extended program modes 7 (plain) and 8 (post-increment) give `mem_addr` = {page_in[5:0], z_hi, z_lo}. Mode 8 writes back that value plus one modulo 2^22: bits 15:0 go to the pointer bytes with `wb_en`, and bits 21:16 go to `page_out` with `page_we`.
- R8: In program modes 5 to 8, `dst_out` is 0 when `use_r0` is 1 and `dst_reg` otherwise. In data modes 0 to 4, `dst_out` is `dst_reg`.
- R9: `mem_space` is 0 for data modes 0 to 4 and 1 for program modes 5 to 8. `mem_we` follows `is_store` in data modes and is 0 in program modes.
- R10: Outputs appear one clock after `op_valid`. If `op_valid` is 0, or the mode code is 9 to 15, then `mem_req`, `wb_en`, `page_we` and `mem_we` are all 0 in the next cycle. After reset, every output is 0.
- R11: Pointer arithmetic wraps modulo 2^16: pre-decrement of 0x0000 gives 0xFFFF, and post-increment of 0xFFFF gives 0x0000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_valid | input | 1 | Operation present this cycle |
| op_mode | input | 4 | Addressing mode code |
| ptr_sel | input | 2 | Pointer pair select |
| x_lo | input | 8 | First pair, low byte |
| x_hi | input | 8 | First pair, high byte |
| y_lo | input | 8 | Second pair, low byte |
| y_hi | input | 8 | Second pair, high byte |
| z_lo | input | 8 | Third pair, low byte |
| z_hi | input | 8 | Third pair, high byte |
| page_in | input | 8 | Page register (low 6 bits used) |
| disp | input | 6 | Unsigned displacement |
| operand | input | 16 | Direct address word |
| is_store | input | 1 | Data access is a write |
| dst_reg | input | 5 | Destination register index |
| use_r0 | input | 1 | Program read targets register 0 |
| mem_req | output | 1 | Memory request strobe |
| mem_space | output | 1 | 0 data memory, 1 program memory |
| mem_we | output | 1 | Write request |
| mem_addr | output | 22 | Access address |
| dst_out | output | 5 | Destination register for loads |
| wb_en | output | 1 | Pointer write-back strobe |
| wb_sel | output | 2 | Pair being written back (0, 1, 2) |
| wb_lo | output | 8 | New pointer low byte |
| wb_hi | output | 8 | New pointer high byte |
| page_we | output | 1 | Page write-back strobe |
| page_out | output | 6 | New page value |

## Verification
The memory request and the pointer write-back land in the same cycle. In extended post-increment, the page update lands there too, so all three strobes and their values must agree within a single output cycle. Random operations across all modes, including unused codes and idle cycles, are compared field by field against a bench model of address and write-back. Directed cases push the pointer to 0x0000 and 0xFFFF and the 22-bit value to 0x3FFFFF. These check that a carry out of the pointer lands in the page and that full wrap clears both.

// File: rtl/ptr_agu.sv
module ptr_agu #(
  parameter int AW = 16,
  parameter int PW = 6,
  parameter int DW = 6,
  parameter int RW = 5,
  localparam int BW = AW / 2,
  localparam int XW = AW + PW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          op_valid,
  input  logic [3:0]    op_mode,
  input  logic [1:0]    ptr_sel,
  input  logic [BW-1:0] x_lo,
  input  logic [BW-1:0] x_hi,
  input  logic [BW-1:0] y_lo,
  input  logic [BW-1:0] y_hi,
  input  logic [BW-1:0] z_lo,
  input  logic [BW-1:0] z_hi,
  input  logic [BW-1:0] page_in,
  input  logic [DW-1:0] disp,
  input  logic [AW-1:0] operand,
  input  logic          is_store,
  input  logic [RW-1:0] dst_reg,
  input  logic          use_r0,
  output logic          mem_req,
  output logic          mem_space,
  output logic          mem_we,
  output logic [XW-1:0] mem_addr,
  output logic [RW-1:0] dst_out,
  output logic          wb_en,
  output logic [1:0]    wb_sel,
  output logic [BW-1:0] wb_lo,
  output logic [BW-1:0] wb_hi,
  output logic          page_we,
  output logic [PW-1:0] page_out
);
  localparam logic [3:0] M_PLAIN = 4'd0, M_PRE = 4'd1, M_POST = 4'd2, M_DISP = 4'd3,
                         M_DIR = 4'd4, M_PRG = 4'd5, M_PRGI = 4'd6, M_EPRG = 4'd7,
                         M_EPRGI = 4'd8;

  logic [AW-1:0] x, y, z, ptr, nxt;
  logic [XW-1:0] ext, ext_inc, addr;
  logic          prog, legal, wbe, pge;
  logic [1:0]    sel;

  assign x    = {x_hi, x_lo};
  assign y    = {y_hi, y_lo};
  assign z    = {z_hi, z_lo};
  assign prog = op_mode inside {M_PRG, M_PRGI, M_EPRG, M_EPRGI};
  assign legal = op_mode <= M_EPRGI;
  assign sel  = prog ? 2'd2 : (ptr_sel[1] ? 2'd2 : ptr_sel);
  assign ptr  = (sel == 2'd0) ? x : (sel == 2'd1) ? y : z;
  assign ext  = {page_in[PW-1:0], z};
  assign ext_inc = ext + 1'b1;

  always_comb begin
    addr = {{PW{1'b0}}, ptr};
    nxt  = ptr;
    wbe  = 1'b0;
    pge  = 1'b0;
    unique case (op_mode)
      M_PRE: begin
        nxt  = ptr - 1'b1;
        addr = {{PW{1'b0}}, nxt};
        wbe  = 1'b1;
      end
      M_POST, M_PRGI: begin
        nxt = ptr + 1'b1;
        wbe = 1'b1;
      end
      M_DISP:
        if (sel != 2'd0) addr = {{PW{1'b0}}, ptr + {{(AW-DW){1'b0}}, disp}};
      M_DIR:   addr = {{PW{1'b0}}, operand};
      M_EPRG:  addr = ext;
      M_EPRGI: begin
        addr = ext;
        nxt  = ext_inc[AW-1:0];
        wbe  = 1'b1;
        pge  = 1'b1;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mem_req   <= 1'b0;
      mem_space <= 1'b0;
      mem_we    <= 1'b0;
      mem_addr  <= '0;
      dst_out   <= '0;
      wb_en     <= 1'b0;
      wb_sel    <= 2'd0;
      wb_lo     <= '0;
      wb_hi     <= '0;
      page_we   <= 1'b0;
      page_out  <= '0;
    end else begin
      mem_req   <= op_valid && legal;
      mem_space <= prog;
      mem_we    <= op_valid && legal && !prog && is_store;
      mem_addr  <= addr;
      dst_out   <= (prog && use_r0) ? '0 : dst_reg;
      wb_en     <= op_valid && wbe;
      wb_sel    <= sel;
      wb_lo     <= nxt[BW-1:0];
      wb_hi     <= nxt[AW-1:BW];
      page_we   <= op_valid && pge;
      page_out  <= ext_inc[XW-1:AW];
    end
  end

  a_r10_wb_with_req: assert property (@(posedge clk) disable iff (!rst_n)
    wb_en |-> mem_req);
  a_r7_page_with_prog_wb: assert property (@(posedge clk) disable iff (!rst_n)
    page_we |-> (wb_en && mem_space));
  a_r9_no_prog_write: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> (mem_req && !mem_space));
  a_r2_r3_wb_near_addr: assert property (@(posedge clk) disable iff (!rst_n)
    (wb_en && !page_we) |-> (({wb_hi, wb_lo} == mem_addr[AW-1:0]) ||
                             ({wb_hi, wb_lo} == mem_addr[AW-1:0] + 1'b1)));
  a_r7_page_carry: assert property (@(posedge clk) disable iff (!rst_n)
    page_we |-> ({page_out, wb_hi, wb_lo} == mem_addr + 1'b1));
  a_r5_direct_addr: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && op_mode == M_DIR) |=> (mem_addr == {{PW{1'b0}}, $past(operand)}));
endmodule

// File: tb/test_ptr_agu.sv
module test_ptr_agu;
  logic clk = 1'b0, rst_n = 1'b0;
  logic op_valid, is_store, use_r0;
  logic [3:0] op_mode;
  logic [1:0] ptr_sel;
  logic [7:0] x_lo, x_hi, y_lo, y_hi, z_lo, z_hi, page_in;
  logic [5:0] disp;
  logic [15:0] operand;
  logic [4:0] dst_reg;
  logic mem_req, mem_space, mem_we, wb_en, page_we;
  logic [21:0] mem_addr;
  logic [4:0] dst_out;
  logic [1:0] wb_sel;
  logic [7:0] wb_lo, wb_hi;
  logic [5:0] page_out;

  int n_vec = 0, n_bad = 0;
  bit done = 0;

  always #2 clk = ~clk;

  ptr_agu i_ptr_agu (.*);

  logic e_req, e_space, e_we, e_wb, e_pg;
  logic [21:0] e_addr;
  logic [4:0] e_dst;
  logic [1:0] e_sel;
  logic [15:0] e_ptr;
  logic [5:0] e_page;

  function automatic string tag_of(input logic [3:0] m);
    case (m)
      4'd0: return "R1";
      4'd1: return "R2";
      4'd2: return "R3";
      4'd3: return "R4";
      4'd4: return "R5";
      4'd5, 4'd6: return "R6";
      4'd7, 4'd8: return "R7";
      default: return "R10";
    endcase
  endfunction

  task automatic model();
    int p, s, full;
    bit prg;
    prg = (op_mode >= 5) && (op_mode <= 8);
    s = prg ? 2 : (ptr_sel >= 2 ? 2 : ptr_sel);
    p = (s == 0) ? {x_hi, x_lo} : (s == 1) ? {y_hi, y_lo} : {z_hi, z_lo};
    full = (page_in & 8'h3f) * 65536 + p;
    e_req = op_valid && op_mode <= 8;
    e_space = prg;
    e_we = e_req && !prg && is_store;
    e_dst = (prg && use_r0) ? 5'd0 : dst_reg;
    e_sel = s[1:0];
    e_wb = 0; e_pg = 0; e_addr = p[21:0]; e_ptr = p[15:0]; e_page = 0;
    case (op_mode)
      4'd1: begin e_ptr = 16'((p + 65535) % 65536); e_addr = {6'd0, e_ptr}; e_wb = op_valid; end
      4'd2, 4'd6: begin e_ptr = 16'((p + 1) % 65536); e_wb = op_valid; end
      4'd3: if (s != 0) e_addr = 22'((p + disp) % 65536);
      4'd4: e_addr = {6'd0, operand};
      4'd7: e_addr = full[21:0];
      4'd8: begin
        e_addr = full[21:0];
        e_ptr = 16'((full + 1) % 65536);
        e_page = 6'(((full + 1) % 4194304) / 65536);
        e_wb = op_valid; e_pg = op_valid;
      end
      default: ;
    endcase
  endtask

  task automatic chk(input string tag, input string what, input int act, input int exp);
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  task automatic apply();
    string t;
    model();
    t = tag_of(op_mode);
    @(negedge clk);
    n_vec++;
    chk(op_valid ? t : "R10", "mem_req", mem_req, e_req);
    chk(op_valid ? t : "R10", "wb_en", wb_en, e_wb);
    chk(op_valid ? "R7" : "R10", "page_we", page_we, e_pg);
    chk("R9", "mem_we", mem_we, e_we);
    if (e_req) begin
      chk(t, "mem_addr", mem_addr, e_addr);
      chk("R9", "mem_space", mem_space, e_space);
      chk("R8", "dst_out", dst_out, e_dst);
    end
    if (e_wb) begin
      chk(t, "wb_sel", wb_sel, e_sel);
      chk(t, "wb_ptr", {wb_hi, wb_lo}, e_ptr);
    end
    if (e_pg) chk("R7", "page_out", page_out, e_page);
  endtask

  task automatic setop(input logic [3:0] m, input logic [1:0] s, input logic [15:0] p,
                       input logic [7:0] pg);
    op_valid = 1; op_mode = m; ptr_sel = s; page_in = pg;
    {x_hi, x_lo} = p; {y_hi, y_lo} = p; {z_hi, z_lo} = p;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed_0a61));
    op_valid = 0; op_mode = 0; ptr_sel = 0; is_store = 0; use_r0 = 0;
    x_lo = 0; x_hi = 0; y_lo = 0; y_hi = 0; z_lo = 0; z_hi = 0;
    page_in = 0; disp = 0; operand = 0; dst_reg = 0;
    repeat (3) @(negedge clk);
    // R10 reset state
    n_vec++;
    chk("R10", "reset_outputs",
        {mem_req, mem_space, mem_we, mem_addr, dst_out, wb_en, wb_sel, wb_lo, wb_hi, page_we, page_out}, 0);
    rst_n = 1;
    @(negedge clk);

    // R11 wrap at both ends
    setop(4'd1, 2'd0, 16'h0000, 8'h00); apply();
    setop(4'd2, 2'd1, 16'hFFFF, 8'h00); apply();
    // R7 carry into page and full wrap
    setop(4'd8, 2'd0, 16'hFFFF, 8'h05); apply();
    setop(4'd8, 2'd0, 16'hFFFF, 8'hFF); apply();
    // R6 16-bit program increment leaves page
    setop(4'd6, 2'd1, 16'hFFFF, 8'h2A); apply();
    // R4 displacement ignored on first pair, applied on third
    disp = 6'h3F;
    setop(4'd3, 2'd0, 16'h1000, 8'h00); apply();
    setop(4'd3, 2'd3, 16'hFFF0, 8'h00); apply();
    // R8 register 0 target
    use_r0 = 1; dst_reg = 5'd17;
    setop(4'd5, 2'd0, 16'h0123, 8'h00); apply();
    // R9 store in program mode is not a write
    is_store = 1;
    setop(4'd7, 2'd0, 16'h4444, 8'h3F); apply();
    // R10 idle and unused code
    op_valid = 0; op_mode = 4'd2; apply();
    setop(4'd12, 2'd0, 16'h5555, 8'h00); apply();

    for (int i = 0; i < 4000; i++) begin
      op_valid = ($urandom_range(0, 9) != 0);
      op_mode = ($urandom_range(0, 15) == 0) ? 4'($urandom_range(9, 15)) : 4'($urandom_range(0, 8));
      ptr_sel = 2'($urandom);
      x_lo = 8'($urandom); x_hi = 8'($urandom);
      y_lo = 8'($urandom); y_hi = 8'($urandom);
      z_lo = 8'($urandom); z_hi = 8'($urandom);
      if ($urandom_range(0, 7) == 0) {z_hi, z_lo} = 16'hFFFF;
      page_in = 8'($urandom);
      disp = 6'($urandom);
      operand = 16'($urandom);
      is_store = 1'($urandom);
      dst_reg = 5'($urandom);
      use_r0 = 1'($urandom);
      apply();
    end
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule